// File: doc/BRIEF.md
# Eight-Operation Arithmetic Unit

This block is a purely combinational arithmetic unit. It takes two operands of a parameterised width and a 3-bit operation select. It returns a result of the same width and one overflow flag. The eight operations are:

- pass-through of either operand
- two's complement negation of either operand
- unsigned addition
- signed addition
- subtraction in either direction

Every arithmetic operation runs on a single ripple-carry adder. An operand-select stage chooses the adder's two inputs and can invert its right-hand input. It also chooses the carry-in. Negation is therefore "zero plus inverted operand plus one", and subtraction is "operand plus inverted operand plus one". A small flag stage picks one of three overflow rules according to the operation.

The unit has no clock and no reset. Its outputs settle from the current inputs alone, so it can sit between registers that belong to the surrounding pipeline.

Top module: `alu8_unit`

## Requirements
- R1: With op_i = 0, x_o equals a_i and v_o is 0.
- R2: With op_i = 1, x_o equals b_i and v_o is 0.
- R3: With op_i = 2, x_o is the two's complement negation of a_i modulo 2^W. v_o is 1 exactly when a_i is the most negative value (MSB set, all other bits clear; 1000 at W = 4).
- R4: With op_i = 3, x_o is the two's complement negation of b_i modulo 2^W. v_o is 1 exactly when b_i is the most negative value.
- R5: With op_i = 4, x_o is (a_i + b_i) mod 2^W with both operands read as unsigned. v_o is the carry out of the MSB, so {v_o, x_o} equals the full W+1-bit unsigned sum.
- R6: With op_i = 5, x_o is (a_i + b_i) mod 2^W with both operands read as signed two's complement. v_o is 1 exactly when the true signed sum lies outside [-2^(W-1), 2^(W-1)-1].
- R7: With op_i = 6, x_o is (a_i - b_i) mod 2^W. v_o is 1 exactly when the true signed difference lies outside the signed range of W bits.
- R8: With op_i = 7, x_o is (b_i - a_i) mod 2^W. v_o is 1 exactly when the true signed difference lies outside the signed range of W bits.
- R9: The outputs depend only on the present inputs. Applying the same inputs again after any earlier sequence gives the same x_o and v_o, with no clock edge involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i  | input  | W | First operand |
| b_i  | input  | W | Second operand |
| op_i | input  | 3 | Operation select, codes 0 to 7 as listed in R1 to R8 |
| x_o  | output | W | Result |
| v_o  | output | 1 | Overflow flag for the selected operation |

## Verification
The bench concentrates on the values where the overflow rules diverge:

- **Most negative operand under negation.** A design that never flags negation would miss a_i = 1000.
- **Subtracting the most negative value.** Here the inverted operand plus carry-in is +2^(W-1), and a flag taken from the wrong adder input sign gets 0 - 1000 wrong.
- **Unsigned wrap versus signed wrap.** 1111 + 0001 must set v_o under code 4 but not under code 5. 0111 + 0001 must do the reverse, which exposes a design that swaps the carry rule and the sign rule.
- **Swapped subtraction order.** A design that swaps the operand order for code 7 gives the negated difference.

An exhaustive sweep of every code and operand pair catches any remaining decode slip.

// File: rtl/alu8_pkg.sv
`timescale 1ns/1ps
package alu8_pkg;

    // Operation select; code values are part of the block's contract.
    typedef enum logic [2:0] {
        OP_PASS_A = 3'd0,
        OP_PASS_B = 3'd1,
        OP_NEG_A  = 3'd2,
        OP_NEG_B  = 3'd3,
        OP_ADD_U  = 3'd4,
        OP_ADD_S  = 3'd5,
        OP_SUB_AB = 3'd6,
        OP_SUB_BA = 3'd7
    } op_e;

    // Overflow rule picked per operation.
    typedef enum logic [1:0] {
        VF_NONE   = 2'd0,
        VF_CARRY  = 2'd1,
        VF_SIGNED = 2'd2
    } vf_e;

endpackage

// File: rtl/alu8_opsel.sv
`timescale 1ns/1ps
module alu8_opsel #(
    parameter int W = 4
) (
    input  logic [W-1:0]   a_i,
    input  logic [W-1:0]   b_i,
    input  alu8_pkg::op_e  op_i,
    output logic [W-1:0]   lhs_o,
    output logic [W-1:0]   rhs_o,
    output logic           cin_o,
    output alu8_pkg::vf_e  vf_o
);
    import alu8_pkg::*;

    localparam logic [W-1:0] ZERO = '0;

    typedef struct packed {
        logic [W-1:0] lhs;
        logic [W-1:0] rhs;
        logic         inv;
        logic         cin;
        vf_e          vf;
    } sel_t;

    sel_t sel_d;

    always_comb begin
        sel_d.lhs = a_i;
        sel_d.rhs = ZERO;
        sel_d.inv = 1'b0;
        sel_d.cin = 1'b0;
        sel_d.vf  = VF_NONE;
        case (op_i)
            OP_PASS_A: begin
                sel_d.lhs = a_i;
            end
            OP_PASS_B: begin
                sel_d.lhs = b_i;
            end
            OP_NEG_A: begin
                sel_d.lhs = ZERO;
                sel_d.rhs = a_i;
                sel_d.inv = 1'b1;
                sel_d.cin = 1'b1;
                sel_d.vf  = VF_SIGNED;
            end
            OP_NEG_B: begin
                sel_d.lhs = ZERO;
                sel_d.rhs = b_i;
                sel_d.inv = 1'b1;
                sel_d.cin = 1'b1;
                sel_d.vf  = VF_SIGNED;
            end
            OP_ADD_U: begin
                sel_d.rhs = b_i;
                sel_d.vf  = VF_CARRY;
            end
            OP_ADD_S: begin
                sel_d.rhs = b_i;
                sel_d.vf  = VF_SIGNED;
            end
            OP_SUB_AB: begin
                sel_d.rhs = b_i;
                sel_d.inv = 1'b1;
                sel_d.cin = 1'b1;
                sel_d.vf  = VF_SIGNED;
            end
            OP_SUB_BA: begin
                sel_d.lhs = b_i;
                sel_d.rhs = a_i;
                sel_d.inv = 1'b1;
                sel_d.cin = 1'b1;
                sel_d.vf  = VF_SIGNED;
            end
            default: begin
                sel_d.lhs = a_i;
            end
        endcase
    end

    assign lhs_o = sel_d.lhs;
    assign rhs_o = sel_d.rhs ^ {W{sel_d.inv}};
    assign cin_o = sel_d.cin;
    assign vf_o  = sel_d.vf;

endmodule

// File: rtl/alu8_ripple.sv
`timescale 1ns/1ps
module alu8_ripple #(
    parameter int W = 4
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    input  logic         cin_i,
    output logic [W-1:0] sum_o,
    output logic         cout_o
);
    logic [W:0] carry;

    assign carry[0] = cin_i;

    for (genvar i = 0; i < W; i++) begin : g_fa
        logic half;
        assign half       = x_i[i] ^ y_i[i];
        assign sum_o[i]   = half ^ carry[i];
        assign carry[i+1] = (x_i[i] & y_i[i]) | (carry[i] & half);
    end

    assign cout_o = carry[W];

endmodule

// File: rtl/alu8_flag.sv
`timescale 1ns/1ps
module alu8_flag (
    input  logic          lhs_msb_i,
    input  logic          rhs_msb_i,
    input  logic          sum_msb_i,
    input  logic          cout_i,
    input  alu8_pkg::vf_e vf_i,
    output logic          v_o
);
    import alu8_pkg::*;

    always_comb begin
        case (vf_i)
            VF_CARRY:  v_o = cout_i;
            VF_SIGNED: v_o = (lhs_msb_i == rhs_msb_i) && (sum_msb_i != lhs_msb_i);
            default:   v_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/alu8_unit.sv
`timescale 1ns/1ps
module alu8_unit #(
    parameter int W = 4
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic [2:0]   op_i,
    output logic [W-1:0] x_o,
    output logic         v_o
);
    import alu8_pkg::*;

    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    op_e          op_d;
    logic [W-1:0] lhs_d;
    logic [W-1:0] rhs_d;
    logic         cin_d;
    vf_e          vf_d;
    logic [W-1:0] sum_d;
    logic         cout_d;

    assign op_d = op_e'(op_i);

    alu8_opsel #(.W(W)) u_opsel (
        .a_i   (a_i),
        .b_i   (b_i),
        .op_i  (op_d),
        .lhs_o (lhs_d),
        .rhs_o (rhs_d),
        .cin_o (cin_d),
        .vf_o  (vf_d)
    );

    alu8_ripple #(.W(W)) u_ripple (
        .x_i    (lhs_d),
        .y_i    (rhs_d),
        .cin_i  (cin_d),
        .sum_o  (sum_d),
        .cout_o (cout_d)
    );

    alu8_flag u_flag (
        .lhs_msb_i (lhs_d[W-1]),
        .rhs_msb_i (rhs_d[W-1]),
        .sum_msb_i (sum_d[W-1]),
        .cout_i    (cout_d),
        .vf_i      (vf_d),
        .v_o       (v_o)
    );

    assign x_o = sum_d;

    // Guards on the assembled datapath, checked against plain arithmetic.
    always_comb begin
        if (op_d == OP_PASS_A) begin
            // R1
            pass_a_chk: assert (x_o == a_i && !v_o);
        end
        if (op_d == OP_NEG_A) begin
            // R3
            neg_a_chk: assert (x_o == W'(-a_i) && v_o == (a_i == MOST_NEG));
        end
        if (op_d == OP_ADD_U) begin
            // R5
            add_u_chk: assert ({v_o, x_o} == ({1'b0, a_i} + {1'b0, b_i}));
        end
        if (op_d == OP_ADD_S) begin
            // R6
            add_s_chk: assert (x_o == W'(a_i + b_i));
        end
        if (op_d == OP_SUB_AB) begin
            // R7
            sub_ab_chk: assert (x_o == W'(a_i - b_i));
        end
    end

endmodule

// File: tb/alu8_unit_bench.sv
`timescale 1ns/1ps
module alu8_unit_bench;

    localparam int W = 4;

    logic         clk = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic [2:0]   op_i = '0;
    logic [W-1:0] x_o;
    logic         v_o;

    int total = 0;
    int bad   = 0;

    always #2.5 clk = ~clk;

    alu8_unit #(.W(W)) u_alu8_unit (
        .a_i  (a_i),
        .b_i  (b_i),
        .op_i (op_i),
        .x_o  (x_o),
        .v_o  (v_o)
    );

    // Reference model from the requirements: returns {v, x}.
    function automatic logic [W:0] ref_model(int op, logic [W-1:0] a, logic [W-1:0] b);
        int ua;
        int ub;
        int sa;
        int sb;
        int r;
        int smax;
        int smin;
        logic v;
        logic [W-1:0] xr;
        ua = int'(a);
        ub = int'(b);
        sa = a[W-1] ? ua - (1 << W) : ua;
        sb = b[W-1] ? ub - (1 << W) : ub;
        smax = (1 << (W-1)) - 1;
        smin = -(1 << (W-1));
        v = 1'b0;
        case (op)
            0: r = ua;
            1: r = ub;
            2: begin r = -sa;     v = (r > smax); end
            3: begin r = -sb;     v = (r > smax); end
            4: begin r = ua + ub; v = (r >= (1 << W)); end
            5: begin r = sa + sb; v = (r > smax) || (r < smin); end
            6: begin r = sa - sb; v = (r > smax) || (r < smin); end
            default: begin r = sb - sa; v = (r > smax) || (r < smin); end
        endcase
        xr = r[W-1:0];
        return {v, xr};
    endfunction

    task automatic check(string req, int op, logic [W-1:0] a, logic [W-1:0] b);
        logic [W:0] exp;
        @(negedge clk);
        op_i = op[2:0];
        a_i  = a;
        b_i  = b;
        #1;
        exp = ref_model(op, a, b);
        total++;
        if ({v_o, x_o} !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%b b=%b got x=%b v=%b exp x=%b v=%b",
                     req, op, a, b, x_o, v_o, exp[W-1:0], exp[W]);
        end
    endtask

    task automatic t_idle();
        // R1: all-zero inputs give a zero result with no overflow
        check("R1", 0, 4'b0000, 4'b0000);
    endtask

    task automatic t_pass();
        check("R1", 0, 4'b1000, 4'b0111);
        check("R1", 0, 4'b1111, 4'b0000);
        check("R2", 1, 4'b1000, 4'b0111);
        check("R2", 1, 4'b0101, 4'b1000);
    endtask

    task automatic t_negate();
        for (int i = 0; i < 16; i++) begin
            check("R3", 2, 4'(i), 4'(15 - i));
            check("R4", 3, 4'(15 - i), 4'(i));
        end
    endtask

    task automatic t_add_unsigned();
        check("R5", 4, 4'b1111, 4'b0001);
        check("R5", 4, 4'b1000, 4'b1000);
        check("R5", 4, 4'b0111, 4'b0001);
        check("R5", 4, 4'b1111, 4'b1111);
    endtask

    task automatic t_add_signed();
        check("R6", 5, 4'b0111, 4'b0001);
        check("R6", 5, 4'b1000, 4'b1111);
        check("R6", 5, 4'b1111, 4'b0001);
        check("R6", 5, 4'b1000, 4'b0111);
    endtask

    task automatic t_subtract();
        check("R7", 6, 4'b0000, 4'b1000);
        check("R7", 6, 4'b1111, 4'b1000);
        check("R7", 6, 4'b1000, 4'b0001);
        check("R7", 6, 4'b0011, 4'b0101);
        check("R8", 7, 4'b1000, 4'b0000);
        check("R8", 7, 4'b1000, 4'b1111);
        check("R8", 7, 4'b0001, 4'b1000);
        check("R8", 7, 4'b0101, 4'b0011);
    endtask

    task automatic t_memoryless();
        // R9: a carrying operation leaves nothing behind
        check("R9", 4, 4'b1111, 4'b1111);
        check("R9", 4, 4'b0000, 4'b0000);
        check("R9", 6, 4'b0000, 4'b1000);
        check("R9", 0, 4'b0011, 4'b0000);
        check("R9", 4, 4'b1111, 4'b1111);
    endtask

    task automatic t_sweep();
        string tags[8] = '{"R1", "R2", "R3", "R4", "R5", "R6", "R7", "R8"};
        for (int op = 0; op < 8; op++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    check(tags[op], op, 4'(a), 4'(b));
                end
            end
        end
    endtask

    initial begin
        t_idle();
        t_pass();
        t_negate();
        t_add_unsigned();
        t_add_signed();
        t_subtract();
        t_memoryless();
        t_sweep();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        total++;
        bad++;
        $display("FAIL watchdog expired before all scenarios ran");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule